// File: doc/BRIEF.md
# Vertical Blanking and Measurement-Line Timing Generator

This block turns the digital components of a decoded sandcastle pulse into the timing signals that steer automatic cut-off and white-level regulation on a picture tube. It counts line edges from the leading edge of the vertical component and forms the vertical blanking window. Inside that window it marks a leakage measurement period, one cut-off strobe for each of red, green and blue in turn, and a white measurement strobe. A 3-bit window select fixes the line positions for the normal-rate and double-rate scan standards. A discharge flag reports a vertical pulse that has run too long.

The line edges come from the horizontal pulse when the sandcastle has three levels. With a two-level sandcastle there is no horizontal component, so the burst-key pulse is used instead. All inputs are plain levels sampled on the system clock. There is no data stream and no handshake, so every pin is a control or status level. The outputs follow the internal state one clock after the input edge that changes it.

Top module: `scan_meas_timer`

## Requirements
- R1: While reset is held, and after it is released with all inputs low, every output is 0.
- R2: One clock after `v_in` is seen high, `vblank` is 1, and it stays 1 for as long as `v_in` stays high.
- R3: With `two_level`=0, rising edges of `h_in` count as line edges and `bk_in` is ignored. With `two_level`=1, rising edges of `bk_in` count and `h_in` is ignored. Line number k is the number of counted edges since the last rising edge of `v_in`.
- R4: Normal-rate selects use a one-line strobe for each of R, G, B and white on consecutive lines, with R on line 19 for `win_sel`=000, 16 for 001 and 22 for 010. The codes 011 and 111 behave as 000.
- R5: Double-rate selects give each strobe two lines, in the order R, G, B, white. R starts on line 38 for 100, 32 for 101 and 44 for 110.
- R6: `leak_strobe` covers the line, or in double-rate the two lines, just before the first R line.
- R7: A vertical pulse that ends before line 4 (line 8 in double-rate) is invalid. For such a pulse no strobe fires and `vblank` simply follows the vertical level.
- R8: After a valid vertical pulse that ended early, `vblank` stays 1 through the last white line and drops when the next line begins.
- R9: If the vertical pulse outlasts the white line, `vblank` drops at the second line edge after the pulse ends.
- R10: While the vertical level is high and k exceeds 29 (57 in double-rate), `cap_discharge` is 1 and all strobes are 0.
- R11: The line count saturates at 31 (63 in double-rate) and restarts at 0 on the next rising edge of `v_in`, which clears `cap_discharge`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_in | input | 1 | Sliced horizontal pulse |
| bk_in | input | 1 | Sliced burst-key pulse |
| v_in | input | 1 | Sliced vertical blanking component |
| two_level | input | 1 | 1: count line edges on burst key |
| win_sel | input | 3 | Standard / scan-rate window select |
| vblank | output | 1 | Vertical blanking window |
| leak_strobe | output | 1 | Leakage measurement period |
| cut_r | output | 1 | Red cut-off measurement line |
| cut_g | output | 1 | Green cut-off measurement line |
| cut_b | output | 1 | Blue cut-off measurement line |
| white_strobe | output | 1 | White measurement line |
| cap_discharge | output | 1 | Overlong vertical pulse flag |

## Verification
The bench walks every window select in both line-clock modes, and on each step it pulses the input that should be ignored. A design that counted the wrong pulse would move every strobe early. Short vertical pulses sit just under the validity limit for each rate. A design that accepted them would fire strobes on a frame that should be ignored. Long pulses test the blanking tail and the discharge threshold. A design that ended blanking at the white line, or that let the count wrap, would drop `vblank` too soon or hold `cap_discharge` into the next frame.

// File: rtl/scan_meas_pkg.sv
package scan_meas_pkg;
  localparam int LINE_W   = 6;
  localparam int CAP_SGL  = 31;
  localparam int CAP_DBL  = 63;
  localparam int DIS_SGL  = 29;
  localparam int DIS_DBL  = 57;
  localparam int VMIN_SGL = 4;
  localparam int VMIN_DBL = 8;

  typedef struct packed {
    logic [LINE_W-1:0] r_line;
    logic              dbl;
  } win_cfg_t;

  function automatic win_cfg_t cfg_of(input logic [2:0] sel);
    win_cfg_t c;
    unique case (sel)
      3'b001:  c = '{r_line: LINE_W'(16), dbl: 1'b0};
      3'b010:  c = '{r_line: LINE_W'(22), dbl: 1'b0};
      3'b100:  c = '{r_line: LINE_W'(38), dbl: 1'b1};
      3'b101:  c = '{r_line: LINE_W'(32), dbl: 1'b1};
      3'b110:  c = '{r_line: LINE_W'(44), dbl: 1'b1};
      default: c = '{r_line: LINE_W'(19), dbl: 1'b0};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sc_line_clock.sv
module sc_line_clock (
  input  logic clk,
  input  logic rst_n,
  input  logic h_in,
  input  logic bk_in,
  input  logic v_in,
  input  logic two_level,
  output logic line_tick,
  output logic v_rise,
  output logic v_lvl
);
  logic h_q, bk_q, v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q  <= 1'b0;
      bk_q <= 1'b0;
      v_q  <= 1'b0;
    end else begin
      h_q  <= h_in;
      bk_q <= bk_in;
      v_q  <= v_in;
    end
  end

  always_comb begin
    line_tick = two_level ? (bk_in & ~bk_q) : (h_in & ~h_q);
    v_rise    = v_in & ~v_q;
    v_lvl     = v_q;
  end
endmodule

// File: rtl/sc_line_counter.sv
module sc_line_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_rise,
  input  logic         line_tick,
  input  logic [W-1:0] cap,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (v_rise)                   count <= '0;
    else if (line_tick && count < cap) count <= count + 1'b1;
  end
endmodule

// File: rtl/sc_frame_state.sv
module sc_frame_state #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_rise,
  input  logic         v_lvl,
  input  logic         line_tick,
  input  logic [W-1:0] count,
  input  logic [W-1:0] vmin,
  output logic         valid,
  output logic [1:0]   tail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tail  <= 2'd0;
    end else if (v_rise) begin
      valid <= 1'b0;
      tail  <= 2'd0;
    end else begin
      if (v_lvl && count >= vmin) valid <= 1'b1;
      if (line_tick && !v_lvl && tail != 2'd2) tail <= tail + 2'd1;
    end
  end
endmodule

// File: rtl/sc_strobe_decode.sv
module sc_strobe_decode
  import scan_meas_pkg::*;
(
  input  logic [LINE_W-1:0] count,
  input  win_cfg_t          cfg,
  input  logic              valid,
  input  logic              v_lvl,
  input  logic [1:0]        tail,
  output logic              vblank,
  output logic              leak_strobe,
  output logic              cut_r,
  output logic              cut_g,
  output logic              cut_b,
  output logic              white_strobe,
  output logic              cap_discharge
);
  logic [LINE_W-1:0] span, leak0, g0, b0, w0, wlast, dlim;
  logic              run;

  function automatic logic in_win(input logic [LINE_W-1:0] c,
                                  input logic [LINE_W-1:0] lo,
                                  input logic [LINE_W-1:0] n);
    return (c >= lo) && (c < lo + n);
  endfunction

  always_comb begin
    span  = cfg.dbl ? LINE_W'(2) : LINE_W'(1);
    leak0 = cfg.r_line - span;
    g0    = cfg.r_line + span;
    b0    = g0 + span;
    w0    = b0 + span;
    wlast = w0 + span - LINE_W'(1);
    dlim  = cfg.dbl ? LINE_W'(DIS_DBL) : LINE_W'(DIS_SGL);

    cap_discharge = v_lvl && (count > dlim);
    run           = valid && !cap_discharge;
    vblank        = v_lvl || (valid && ((count <= wlast) || (tail != 2'd2)));

    leak_strobe  = run && in_win(count, leak0, span);
    cut_r        = run && in_win(count, cfg.r_line, span);
    cut_g        = run && in_win(count, g0, span);
    cut_b        = run && in_win(count, b0, span);
    white_strobe = run && in_win(count, w0, span);
  end
endmodule

// File: rtl/scan_meas_timer.sv
module scan_meas_timer
  import scan_meas_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       h_in,
  input  logic       bk_in,
  input  logic       v_in,
  input  logic       two_level,
  input  logic [2:0] win_sel,
  output logic       vblank,
  output logic       leak_strobe,
  output logic       cut_r,
  output logic       cut_g,
  output logic       cut_b,
  output logic       white_strobe,
  output logic       cap_discharge
);
  logic              line_tick, v_rise, v_lvl, valid;
  logic [1:0]        tail;
  logic [LINE_W-1:0] count, cap, vmin;
  win_cfg_t          cfg;

  always_comb begin
    cfg  = cfg_of(win_sel);
    cap  = cfg.dbl ? LINE_W'(CAP_DBL)  : LINE_W'(CAP_SGL);
    vmin = cfg.dbl ? LINE_W'(VMIN_DBL) : LINE_W'(VMIN_SGL);
  end

  sc_line_clock u_clk (
    .clk(clk), .rst_n(rst_n), .h_in(h_in), .bk_in(bk_in), .v_in(v_in),
    .two_level(two_level), .line_tick(line_tick), .v_rise(v_rise), .v_lvl(v_lvl)
  );

  sc_line_counter #(.W(LINE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .v_rise(v_rise), .line_tick(line_tick),
    .cap(cap), .count(count)
  );

  sc_frame_state #(.W(LINE_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .v_rise(v_rise), .v_lvl(v_lvl),
    .line_tick(line_tick), .count(count), .vmin(vmin),
    .valid(valid), .tail(tail)
  );

  sc_strobe_decode u_dec (
    .count(count), .cfg(cfg), .valid(valid), .v_lvl(v_lvl), .tail(tail),
    .vblank(vblank), .leak_strobe(leak_strobe), .cut_r(cut_r), .cut_g(cut_g),
    .cut_b(cut_b), .white_strobe(white_strobe), .cap_discharge(cap_discharge)
  );
endmodule

// File: rtl/scan_meas_timer_chk.sv
module scan_meas_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic v_in,
  input logic vblank,
  input logic leak_strobe,
  input logic cut_r,
  input logic cut_g,
  input logic cut_b,
  input logic white_strobe,
  input logic cap_discharge
);
  logic any_strobe;
  assign any_strobe = leak_strobe | cut_r | cut_g | cut_b | white_strobe;

  a_r2_v_opens_blank: assert property (@(posedge clk) disable iff (!rst_n)
    v_in |=> vblank);

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({leak_strobe, cut_r, cut_g, cut_b, white_strobe}));

  a_r8_strobe_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> vblank);

  a_r10_discharge_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    cap_discharge |-> (!any_strobe && vblank));

  a_r11_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && !$past(v_in)) |=> !cap_discharge);
endmodule

bind scan_meas_timer scan_meas_timer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .v_in(v_in), .vblank(vblank),
  .leak_strobe(leak_strobe), .cut_r(cut_r), .cut_g(cut_g), .cut_b(cut_b),
  .white_strobe(white_strobe), .cap_discharge(cap_discharge)
);

// File: tb/test_scan_meas_timer.sv
module test_scan_meas_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_in = 1'b0, bk_in = 1'b0, v_in = 1'b0, two_level = 1'b0;
  logic [2:0] win_sel = 3'b000;
  logic vblank, leak_strobe, cut_r, cut_g, cut_b, white_strobe, cap_discharge;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scan_meas_timer i_scan_meas_timer (
    .clk(clk), .rst_n(rst_n), .h_in(h_in), .bk_in(bk_in), .v_in(v_in),
    .two_level(two_level), .win_sel(win_sel), .vblank(vblank),
    .leak_strobe(leak_strobe), .cut_r(cut_r), .cut_g(cut_g), .cut_b(cut_b),
    .white_strobe(white_strobe), .cap_discharge(cap_discharge)
  );

  typedef struct packed {
    logic [2:0] sel;
    logic       mode;
    logic [7:0] vlen;
    logic [7:0] nlines;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 1'b0, 8'd5,  8'd26},  // R4 R6 R8
    '{3'b001, 1'b0, 8'd5,  8'd22},  // R4 R6 R8
    '{3'b010, 1'b1, 8'd4,  8'd28},  // R3 burst-key clock, R4 at validity limit
    '{3'b011, 1'b0, 8'd6,  8'd26},  // R4 alias of 000
    '{3'b111, 1'b1, 8'd5,  8'd26},  // R4 alias of 000, R3
    '{3'b100, 1'b0, 8'd9,  8'd54},  // R5 R6
    '{3'b101, 1'b1, 8'd8,  8'd42},  // R5 at double-rate limit, R3
    '{3'b110, 1'b0, 8'd10, 8'd54},  // R5
    '{3'b000, 1'b0, 8'd3,  8'd10},  // R7 too short
    '{3'b100, 1'b0, 8'd7,  8'd20},  // R7 too short, double rate
    '{3'b000, 1'b0, 8'd35, 8'd40},  // R10 R9 R11 saturation at 31
    '{3'b110, 1'b0, 8'd60, 8'd66},  // R11 restart, R10 R9 saturation at 63
    '{3'b001, 1'b0, 8'd24, 8'd28}   // R9 tail past white line
  };

  // Expected {vblank, discharge, leak, r, g, b, white} after k line edges.
  function automatic logic [6:0] expect_of(input logic [2:0] sel, input int vlen,
                                           input int k, input bit vhigh);
    int r; bit dbl; int sp, vmin, dlim, wl, tl;
    bit valid, dis, run;
    logic [6:0] e;
    dbl = (sel == 3'b100) || (sel == 3'b101) || (sel == 3'b110);
    case (sel)
      3'b001: r = 16;  3'b010: r = 22;  3'b100: r = 38;
      3'b101: r = 32;  3'b110: r = 44;  default: r = 19;
    endcase
    sp   = dbl ? 2 : 1;
    vmin = dbl ? 8 : 4;
    dlim = dbl ? 57 : 29;
    wl   = r + 4*sp - 1;
    valid = (vlen >= vmin);
    tl   = vhigh ? 0 : ((k - vlen) > 2 ? 2 : (k - vlen));
    dis  = vhigh && (k > dlim);
    run  = valid && !dis;
    e[6] = vhigh || (valid && (k <= wl || tl < 2));
    e[5] = dis;
    e[4] = run && k >= r - sp   && k < r;
    e[3] = run && k >= r        && k < r + sp;
    e[2] = run && k >= r + sp   && k < r + 2*sp;
    e[1] = run && k >= r + 2*sp && k < r + 3*sp;
    e[0] = run && k >= r + 3*sp && k < r + 4*sp;
    return e;
  endfunction

  function automatic logic [6:0] outs();
    return {vblank, cap_discharge, leak_strobe, cut_r, cut_g, cut_b, white_strobe};
  endfunction

  task automatic check(input string req, input logic [6:0] exp_v);
    n_vec++;
    if (outs() !== exp_v) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b", req, outs(), exp_v);
    end
  endtask

  task automatic pulse(input bit on_bk);
    @(negedge clk); if (on_bk) bk_in = 1'b1; else h_in = 1'b1;
    @(negedge clk); bk_in = 1'b0; h_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_v(input logic val);
    @(negedge clk); v_in = val;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", 7'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", 7'b0);

    // R2: blanking one clock after vertical goes high
    @(negedge clk); v_in = 1'b1;
    @(negedge clk);
    check("R2", 7'b1000000);
    repeat (5) @(negedge clk);
    check("R2", 7'b1000000);
    set_v(1'b0);
    check("R7", 7'b0);

    foreach (VECS[i]) begin
      vec_t vc;
      bit vhigh;
      vc = VECS[i];
      @(negedge clk); win_sel = vc.sel; two_level = vc.mode;
      set_v(1'b1);
      vhigh = 1'b1;
      check("R11", expect_of(vc.sel, vc.vlen, 0, 1'b1));
      for (int k = 1; k <= int'(vc.nlines); k++) begin
        pulse(!vc.mode);   // R3: ignored source
        pulse(vc.mode);    // counted source
        if (k == int'(vc.vlen)) begin
          set_v(1'b0);
          vhigh = 1'b0;
        end
        check(vc.vlen < 8 && vc.sel[2] ? "R7" :
              vc.vlen > 29 ? "R10" : vc.vlen > 20 ? "R9" :
              vc.sel[2] ? "R5" : "R4",
              expect_of(vc.sel, vc.vlen, k, vhigh));
      end
      if (vhigh) set_v(1'b0);
    end

    // R11: after a saturated long frame, a new vertical edge restarts at line 0
    @(negedge clk); win_sel = 3'b000; two_level = 1'b0;
    set_v(1'b1);
    for (int k = 1; k <= 33; k++) pulse(1'b0);
    check("R10", 7'b1100000);
    set_v(1'b0);
    set_v(1'b1);
    check("R11", 7'b1000000);
    set_v(1'b0);
    check("R7", 7'b0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule